// File: doc/BRIEF.md
# Auxiliary External Interrupt Controller

This block gives an 8051-style core two more external interrupt lines next to its two standard ones. Each line is active low and asynchronous. It passes through a two-flop synchroniser, and it is then judged at machine-cycle strobes. Two detection modes are available. In falling-edge mode, a high sample at one strobe followed by a low sample at the next strobe latches a pending flag. In low-level mode, the synchronised low input drives the request directly.

Every control bit for both lines sits in one 8-bit special-function register. The core reaches it with byte writes and reads, and with single-bit set and clear writes that use the bit address. For each line the block drives a request to the core's interrupt arbiter, qualified by the line's enable. It also drives a high-priority tag for that request. When the arbiter takes a vector it pulses the acknowledge for that line. In edge mode the acknowledge clears the pending flag.

Top module: `xirq_unit`

## Requirements
- R1: After reset, all eight register bits are 0 and both request outputs are low.
- R2: A byte write to address C0H replaces the register, and a read at C0H returns it in the same cycle. A byte write to any other address leaves the register unchanged. A read at any other address returns 0.
- R3: A bit write to a bit address from C0H to C7H loads bit (address − C0H) with the written value and leaves the other bits alone. Bit addresses outside that range have no effect.
- R4: Register layout, from bit 7 down to bit 0: line 1 priority, line 1 enable, line 1 pending, line 1 mode, then line 0 priority, line 0 enable, line 0 pending, line 0 mode. A mode bit of 1 selects falling edge and 0 selects low level.
- R5: In edge mode, the pending flag is set at a clock edge where mc_tick_i is high, the synchronised input was high at the previous strobe and is low now. If the strobe is high every cycle, the flag is visible after the third rising edge following the input's fall. No strobe means no detection.
- R6: In edge mode, an acknowledge clears the pending flag at the next edge. In level mode, an acknowledge has no effect.
- R7: In level mode, the request equals the enable ANDed with the synchronised low input, two edges after the input changes. The input never changes the pending flag.
- R8: A request is raised only when that line's enable bit is 1. In edge mode it also needs the pending flag.
- R9: req_hi_o for a line is high exactly when that line's request is high and its priority bit is 1.
- R10: If a detected edge coincides with an acknowledge or with a software write to the register, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_tick_i | input | 1 | Machine-cycle strobe that gates input sampling |
| irq_ni | input | 2 | Asynchronous interrupt inputs, active low |
| sfr_addr_i | input | 8 | SFR byte address for read and byte write |
| sfr_wr_i | input | 1 | Byte write strobe |
| sfr_wdata_i | input | 8 | Byte write data |
| sfr_bwr_i | input | 1 | Bit write strobe |
| sfr_baddr_i | input | 8 | Bit address for a bit write |
| sfr_bval_i | input | 1 | Value written by a bit write |
| sfr_rdata_o | output | 8 | Read data, which is 0 when the address is not C0H |
| ack_i | input | 2 | Vector-taken acknowledge, one bit per line |
| req_o | output | 2 | Requests to the arbiter |
| req_hi_o | output | 2 | High-priority tag for each request |

## Verification
Register writes and acknowledges take effect at the capturing edge, so read data and requests are checked in the middle of the following cycle. A level-mode input change reaches req_o after two edges. A falling edge reaches the pending flag after three edges when the strobe runs every cycle, and the directed probes are placed on both sides of that edge to catch an early or a late flag. Inputs are driven just after each rising edge and outputs are sampled at the falling edge. A per-cycle bench model, built from the requirements, predicts every output for the random traffic.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned XIRQ_CH = 2;
  localparam int unsigned CH_W    = 4;
  localparam int unsigned SFR_W   = 8;
  localparam logic [7:0]  XIRQ_ADDR = 8'hC0;

  // bit position of each field inside a channel nibble
  localparam int unsigned POS_TRIG = 0;
  localparam int unsigned POS_PEND = 1;
  localparam int unsigned POS_EN   = 2;
  localparam int unsigned POS_PRIO = 3;

  typedef struct packed {
    logic prio;
    logic en;
    logic pend;
    logic trig;
  } ch_ctl_t;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  // idle level of an active-low line is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/xirq_edge.sv
module xirq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lvl_ni,
  output logic fall_o
);
  logic samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     samp_q <= 1'b1;
    else if (tick_i) samp_q <= lvl_ni;
  end

  // high at previous strobe, low at this one
  assign fall_o = tick_i & samp_q & ~lvl_ni;
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned N_CH = XIRQ_CH,
  parameter logic [7:0]  ADDR = XIRQ_ADDR
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [7:0]              sfr_addr_i,
  input  logic                    sfr_wr_i,
  input  logic [SFR_W-1:0]        sfr_wdata_i,
  input  logic                    sfr_bwr_i,
  input  logic [7:0]              sfr_baddr_i,
  input  logic                    sfr_bval_i,
  input  logic [N_CH-1:0]         hw_set_i,
  input  logic [N_CH-1:0]         hw_clr_i,
  output ch_ctl_t [N_CH-1:0]      ctl_o,
  output logic [SFR_W-1:0]        rdata_o,
  output logic                    sw_wr_o
);
  localparam int unsigned REG_W = N_CH * CH_W;
  localparam int unsigned IDX_W = $clog2(SFR_W);

  if (REG_W != SFR_W) begin : g_bad_width
    $error("xirq_regs: channel count must fill one SFR byte");
  end

  logic [REG_W-1:0] reg_q, reg_d;
  logic             byte_hit, bit_hit;
  logic [IDX_W-1:0] bit_idx;

  assign byte_hit = sfr_wr_i && (sfr_addr_i == ADDR);
  assign bit_hit  = sfr_bwr_i && (sfr_baddr_i[7:IDX_W] == ADDR[7:IDX_W]);
  assign bit_idx  = sfr_baddr_i[IDX_W-1:0];
  assign sw_wr_o  = byte_hit | bit_hit;

  // software first, then ack clear, then hardware set wins
  always_comb begin
    reg_d = reg_q;
    if (byte_hit) reg_d = sfr_wdata_i[REG_W-1:0];
    if (bit_hit)  reg_d[bit_idx] = sfr_bval_i;
    for (int k = 0; k < int'(N_CH); k++) begin
      if (hw_clr_i[k]) reg_d[k*CH_W + POS_PEND] = 1'b0;
      if (hw_set_i[k]) reg_d[k*CH_W + POS_PEND] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= '0;
    else         reg_q <= reg_d;
  end

  assign ctl_o   = reg_q;
  assign rdata_o = (sfr_addr_i == ADDR) ? SFR_W'(reg_q) : '0;

  // R2
  byte_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_hit && !bit_hit && hw_set_i == '0 && hw_clr_i == '0
    |=> rdata_o == $past(sfr_wdata_i) || sfr_addr_i != ADDR);

  // R3
  bit_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_hit && hw_set_i == '0 && hw_clr_i == '0
    |=> reg_q[$past(bit_idx)] == $past(sfr_bval_i));
endmodule

// File: rtl/xirq_unit.sv
module xirq_unit
  import xirq_pkg::*;
#(
  parameter int unsigned N_CH     = XIRQ_CH,
  parameter logic [7:0]  SFR_ADDR = XIRQ_ADDR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mc_tick_i,
  input  logic [N_CH-1:0]   irq_ni,
  input  logic [7:0]        sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic [SFR_W-1:0]  sfr_wdata_i,
  input  logic              sfr_bwr_i,
  input  logic [7:0]        sfr_baddr_i,
  input  logic              sfr_bval_i,
  output logic [SFR_W-1:0]  sfr_rdata_o,
  input  logic [N_CH-1:0]   ack_i,
  output logic [N_CH-1:0]   req_o,
  output logic [N_CH-1:0]   req_hi_o
);
  logic [N_CH-1:0]    irq_sync_n, fall, hw_set, hw_clr;
  ch_ctl_t [N_CH-1:0] ctl;
  logic               sw_wr;

  xirq_sync #(.W(N_CH)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_ni),
    .q_o   (irq_sync_n)
  );

  xirq_regs #(.N_CH(N_CH), .ADDR(SFR_ADDR)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sfr_addr_i (sfr_addr_i),
    .sfr_wr_i   (sfr_wr_i),
    .sfr_wdata_i(sfr_wdata_i),
    .sfr_bwr_i  (sfr_bwr_i),
    .sfr_baddr_i(sfr_baddr_i),
    .sfr_bval_i (sfr_bval_i),
    .hw_set_i   (hw_set),
    .hw_clr_i   (hw_clr),
    .ctl_o      (ctl),
    .rdata_o    (sfr_rdata_o),
    .sw_wr_o    (sw_wr)
  );

  for (genvar ch = 0; ch < int'(N_CH); ch++) begin : g_ch
    xirq_edge i_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(mc_tick_i),
      .lvl_ni(irq_sync_n[ch]),
      .fall_o(fall[ch])
    );

    // pending flag is hardware-managed only in edge mode
    assign hw_set[ch]   = fall[ch]  & ctl[ch].trig;
    assign hw_clr[ch]   = ack_i[ch] & ctl[ch].trig;
    assign req_o[ch]    = ctl[ch].en & (ctl[ch].trig ? ctl[ch].pend : ~irq_sync_n[ch]);
    assign req_hi_o[ch] = req_o[ch] & ctl[ch].prio;

    // R5
    edge_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall[ch] && ctl[ch].trig |=> ctl[ch].pend);

    // R6
    ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[ch] && ctl[ch].trig && !fall[ch] && !sw_wr |=> !ctl[ch].pend);

    // R7
    lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctl[ch].trig && !sw_wr |=> $stable(ctl[ch].pend));

    // R8
    req_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o[ch] |-> ctl[ch].en);

    // R9
    req_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_hi_o[ch] |-> req_o[ch] && ctl[ch].prio);
  end
endmodule

// File: tb/test_xirq_unit.sv
module test_xirq_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_REG = 8'hC0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] irq_n = 2'b11;
  logic [7:0] addr = A_REG;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       bwr = 1'b0;
  logic [7:0] baddr = '0;
  logic       bval = 1'b0;
  logic [1:0] ack = '0;
  logic [7:0] rdata;
  logic [1:0] req, req_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xirq_unit i_xirq_unit (
    .clk_i(clk), .rst_ni(rst_n), .mc_tick_i(tick), .irq_ni(irq_n),
    .sfr_addr_i(addr), .sfr_wr_i(wr), .sfr_wdata_i(wdata),
    .sfr_bwr_i(bwr), .sfr_baddr_i(baddr), .sfr_bval_i(bval),
    .sfr_rdata_o(rdata), .ack_i(ack), .req_o(req), .req_hi_o(req_hi)
  );

  // reference model from the requirements
  logic [7:0] m_reg;
  logic [1:0] m_s1, m_s2, m_smp;

  function automatic logic [1:0] exp_req(logic [7:0] r, logic [1:0] s);
    logic [1:0] q;
    for (int k = 0; k < 2; k++)
      q[k] = r[4*k+2] & (r[4*k] ? r[4*k+1] : ~s[k]);
    return q;
  endfunction

  function automatic logic [1:0] exp_hi(logic [7:0] r, logic [1:0] s);
    logic [1:0] q = exp_req(r, s);
    return {q[1] & r[7], q[0] & r[3]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = '0; m_s1 = '1; m_s2 = '1; m_smp = '1;
    end else begin
      logic [7:0] n;
      n = m_reg;
      if (wr && addr == A_REG) n = wdata;
      if (bwr && baddr[7:3] == A_REG[7:3]) n[baddr[2:0]] = bval;
      for (int k = 0; k < 2; k++) begin
        if (m_reg[4*k] && ack[k]) n[4*k+1] = 1'b0;
        if (m_reg[4*k] && tick && m_smp[k] && !m_s2[k]) n[4*k+1] = 1'b1;
      end
      m_reg = n;
      if (tick) m_smp = m_s2;
      m_s2 = m_s1;
      m_s1 = irq_n;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2", rdata, (addr == A_REG) ? m_reg : 8'h00, "model rdata");
    chk("R8", req, exp_req(m_reg, m_s2), "model req");
    chk("R9", req_hi, exp_hi(m_reg, m_s2), "model req_hi");
  end

  task automatic nxt();
    @(posedge clk); #2;
  endtask

  task automatic put_byte(logic [7:0] a, logic [7:0] d);
    nxt(); addr = a; wdata = d; wr = 1'b1;
    nxt(); wr = 1'b0; addr = A_REG;
  endtask

  task automatic put_bit(logic [7:0] ba, logic v);
    nxt(); baddr = ba; bval = v; bwr = 1'b1;
    nxt(); bwr = 1'b0;
  endtask

  task automatic pulse_ack(int k);
    nxt(); ack[k] = 1'b1;
    nxt(); ack = '0;
  endtask

  task automatic probe(string tag, logic [7:0] e_rd, logic [1:0] e_req, logic [1:0] e_hi);
    @(negedge clk);
    chk(tag, rdata, e_rd, "rdata");
    chk(tag, req, e_req, "req");
    chk(tag, req_hi, e_hi, "req_hi");
  endtask

  task automatic settle();
    irq_n = 2'b11; repeat (4) nxt();
    put_byte(A_REG, 8'h00);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    probe("R1", 8'h00, 2'b00, 2'b00);

    // R2 byte access, foreign address ignored
    put_byte(A_REG, 8'hA5);
    probe("R2", 8'hA5, 2'b00, 2'b00);
    put_byte(8'hC1, 8'h00);
    probe("R2", 8'hA5, 2'b00, 2'b00);
    nxt(); addr = 8'hC1;
    @(negedge clk); chk("R2", rdata, 8'h00, "rdata off-address");
    nxt(); addr = A_REG;

    // R3 R4 bit writes
    put_byte(A_REG, 8'h00);
    put_bit(8'hC2, 1'b1);
    probe("R3", 8'h04, 2'b00, 2'b00);
    put_bit(8'hC8, 1'b1);
    probe("R3", 8'h04, 2'b00, 2'b00);
    put_bit(8'hC7, 1'b1);
    probe("R4", 8'h84, 2'b00, 2'b00);
    put_bit(8'hC7, 1'b0);
    probe("R3", 8'h04, 2'b00, 2'b00);

    // R5 edge timing on line 0
    put_byte(A_REG, 8'h05);
    irq_n[0] = 1'b0;
    nxt(); nxt();
    probe("R5", 8'h05, 2'b00, 2'b00);
    nxt();
    probe("R5", 8'h07, 2'b01, 2'b00);

    // R6 ack clears, held-low input makes no new edge
    pulse_ack(0);
    probe("R6", 8'h05, 2'b00, 2'b00);
    repeat (3) nxt();
    probe("R6", 8'h05, 2'b00, 2'b00);
    settle();

    // R9 priority tag
    put_byte(A_REG, 8'h0D);
    irq_n[0] = 1'b0;
    repeat (3) nxt();
    probe("R9", 8'h0F, 2'b01, 2'b01);
    pulse_ack(0);
    settle();

    // R10 edge vs ack in the same cycle
    put_byte(A_REG, 8'h05);
    irq_n[0] = 1'b0;
    nxt(); nxt(); ack[0] = 1'b1;
    nxt(); ack = '0;
    probe("R10", 8'h07, 2'b01, 2'b00);
    pulse_ack(0);
    settle();

    // R10 edge vs software clear in the same cycle
    put_byte(A_REG, 8'h05);
    irq_n[0] = 1'b0;
    nxt(); nxt(); wdata = 8'h05; wr = 1'b1;
    nxt(); wr = 1'b0;
    probe("R10", 8'h07, 2'b01, 2'b00);
    pulse_ack(0);
    settle();

    // R8 enable gates the request
    put_byte(A_REG, 8'h01);
    irq_n[0] = 1'b0;
    repeat (3) nxt();
    probe("R8", 8'h03, 2'b00, 2'b00);
    put_bit(8'hC2, 1'b1);
    probe("R8", 8'h07, 2'b01, 2'b00);
    pulse_ack(0);
    settle();

    // R7 level mode on line 1
    put_byte(A_REG, 8'h40);
    irq_n[1] = 1'b0;
    nxt();
    probe("R7", 8'h40, 2'b00, 2'b00);
    nxt();
    probe("R7", 8'h40, 2'b10, 2'b00);
    irq_n[1] = 1'b1;
    nxt(); nxt();
    probe("R7", 8'h40, 2'b00, 2'b00);

    // R6 ack ignored in level mode
    put_byte(A_REG, 8'h60);
    probe("R6", 8'h60, 2'b00, 2'b00);
    pulse_ack(1);
    probe("R6", 8'h60, 2'b00, 2'b00);
    settle();

    // R5 no strobe, no detection; one strobe detects
    tick = 1'b0;
    put_byte(A_REG, 8'h05);
    irq_n[0] = 1'b0;
    repeat (5) nxt();
    probe("R5", 8'h05, 2'b00, 2'b00);
    nxt(); tick = 1'b1;
    nxt(); tick = 1'b0;
    probe("R5", 8'h07, 2'b01, 2'b00);
    tick = 1'b1;
    pulse_ack(0);
    settle();

    // random traffic checked by the model
    for (int i = 0; i < 4000; i++) begin
      nxt();
      tick  = ($urandom_range(3) != 0);
      wr    = ($urandom_range(9) == 0);
      addr  = ($urandom_range(3) == 0) ? 8'($urandom_range(255)) : A_REG;
      wdata = 8'($urandom_range(255));
      bwr   = ($urandom_range(7) == 0);
      baddr = 8'hC0 + 8'($urandom_range(9));
      bval  = 1'($urandom_range(1));
      ack   = 2'($urandom_range(3)) & {($urandom_range(5) == 0), ($urandom_range(5) == 0)};
      if ($urandom_range(5) == 0) irq_n = 2'($urandom_range(3));
    end
    nxt(); wr = 1'b0; bwr = 1'b0; ack = '0;
    nxt();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule